// File: doc/BRIEF.md
# Packet-Aligned Video Stream Crossbar

This block connects a set of valid/ready pixel streams to a set of output streams. Each beat carries a pixel word together with start-of-packet and end-of-packet flags. Every output takes its stream from at most one input, and every input feeds at most one output. An input that is not connected is held stalled, because its ready is kept low. Within a packet, the valid, data and packet flags travel from the selected input to its output with no register in between, and the output's ready travels back to that input.

The connection pattern is set through a small register-mapped control port. Software may write the per-output selection registers at any time, but they are copied into the working routing only while the crossbar is halted. A halt request does not take effect at once. Every connected input first finishes its current image packet by having an end-of-packet beat accepted, and the crossbar stops only after that, so all streams halt on a common packet boundary.

A new pattern can be loaded in two ways. Software can clear the enable register, wait for the status register to read zero, and then set the enable register again. Alternatively, writing the switch register runs the same halt, reload and restart sequence with no software involvement, and that register clears itself when the sequence is done.

Top module: `vxbar`

## Requirements
- R1: While reset is held, and after it is released, every output has valid low, every input has ready low, and the enable, status, switch and selection registers all read 0.
- R2: Selection register value 0 disables its output. A value k in 1..NUM_IN connects input k-1. Any value above NUM_IN disables the output. While running, the valid, data, start and end flags of a connected output equal those of its input in the same cycle, and that input's ready equals the output's ready.
- R3: If the staged selections name one input for two outputs, the lower-numbered output gets the input and the other output is disabled. The number of accepted beats at the inputs always equals the number of accepted beats at the outputs.
- R4: A disabled output drives valid, start, end and data as 0, and an input connected to no output drives ready 0.
- R5: A write to a selection register while running is readable at once but leaves the working routing unchanged.
- R6: After a halt request (enable written 0), each connected input keeps flowing until it has an end-of-packet beat accepted, and is stalled from then on. Status stays 1 until every connected input has done this.
- R7: Once halted, status reads 0 and no input is ready and no output is valid. Writing enable 1 then loads the staged selections and resumes flow.
- R8: Writing 1 to the switch register performs halt, wait, reload and restart by itself. The register reads 1 until restart and 0 after it, and enable reads 1 after the sequence. Unconnected inputs do not hold up the halt.
- R9: Register map (word addresses): 0 enable (bit 0), 1 status (bit 0), 2 switch (bit 0), 3+j selection for output j. Other addresses read 0.
- R10: Driving rst_n low forces outputs invalid and inputs not ready at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| ctl_wr | input | 1 | Register write strobe |
| ctl_addr | input | AW | Register word address |
| ctl_wdata | input | REG_W | Register write data |
| ctl_rdata | output | REG_W | Read data for ctl_addr, combinational |
| in_valid | input | NUM_IN | Per-input beat valid |
| in_ready | output | NUM_IN | Per-input ready |
| in_sop | input | NUM_IN | Per-input start-of-packet flag |
| in_eop | input | NUM_IN | Per-input end-of-packet flag |
| in_data | input | NUM_IN*DATA_W | Input pixel words, input i at slice i |
| out_valid | output | NUM_OUT | Per-output beat valid |
| out_ready | input | NUM_OUT | Per-output ready from downstream |
| out_sop | output | NUM_OUT | Per-output start-of-packet flag |
| out_eop | output | NUM_OUT | Per-output end-of-packet flag |
| out_data | output | NUM_OUT*DATA_W | Output pixel words, output j at slice j |

## Verification
The checker watches the cycle-level invariants on every clock. Accepted beats are conserved between the input side and the output side. No more outputs are valid than inputs. The working routing stays fixed while running. A halted crossbar moves nothing. A self-clearing switch always leaves the crossbar running. The bench scenarios are the only place to show the ordered part of the behaviour. That covers an input stalling right after its own end-of-packet while another keeps flowing, status dropping only after the last connected input finishes, the exact cycle at which the new routing appears, lower-output priority for a duplicated selection, and out-of-range selections disabling an output.

// File: rtl/vxbar_pkg.sv
// Package: shared constants and the run-state type for the crossbar.
// Assumes word addressing on the control port.
package vxbar_pkg;

    // Run-state of the crossbar sequencer.
    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } xbar_state_e;

    // Control register word addresses; selection registers follow in output order.
    localparam int REG_ENABLE = 0;
    localparam int REG_STATUS = 1;
    localparam int REG_SWITCH = 2;
    localparam int REG_ROUTE0 = 3;

endpackage

// File: rtl/vxbar_regs.sv
// Module: control-port register file. Holds the enable bit, the self-clearing
// switch request and one staged selection per output, and returns read data
// combinationally. Assumes SEL_W <= REG_W and one access per cycle.
module vxbar_regs
    import vxbar_pkg::*;
#(
    parameter int NUM_OUT = 2,
    parameter int SEL_W   = 2,
    parameter int REG_W   = 8,
    parameter int AW      = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [AW-1:0]            addr,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         rdata,
    input  logic                     busy,
    input  logic                     seq_done,
    output logic                     enable_o,
    output logic                     switch_o,
    output logic [NUM_OUT*SEL_W-1:0] staged_o
);

    logic             enable_q;
    logic             switch_q;
    logic [SEL_W-1:0] staged_q [NUM_OUT];

    // Enable and switch bits: software writes, sequencer completion overrides.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            switch_q <= 1'b0;
        end else if (seq_done) begin
            enable_q <= 1'b1;
            switch_q <= 1'b0;
        end else if (wr) begin
            if (addr == AW'(REG_ENABLE)) enable_q <= wdata[0];
            if (addr == AW'(REG_SWITCH) && wdata[0]) switch_q <= 1'b1;
        end
    end

    // Staged selection registers, one per output.
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                staged_q[o] <= '0;
            end else if (wr && addr == AW'(REG_ROUTE0 + o)) begin
                staged_q[o] <= wdata[SEL_W-1:0];
            end
        end
        assign staged_o[o*SEL_W +: SEL_W] = staged_q[o];
    end

    // Read multiplexer over the register map.
    always_comb begin
        int idx;
        idx   = int'(addr) - REG_ROUTE0;
        rdata = '0;
        if (addr == AW'(REG_ENABLE)) begin
            rdata[0] = enable_q;
        end else if (addr == AW'(REG_STATUS)) begin
            rdata[0] = busy;
        end else if (addr == AW'(REG_SWITCH)) begin
            rdata[0] = switch_q;
        end else if (idx >= 0 && idx < NUM_OUT) begin
            rdata[SEL_W-1:0] = staged_q[idx];
        end
    end

    assign enable_o = enable_q;
    assign switch_o = switch_q;

endmodule

// File: rtl/vxbar_resolve.sv
// Module: turns staged selections into a legal one-to-one routing. Values
// outside 1..NUM_IN become 0, and a selection already taken by a lower
// output becomes 0. Purely combinational.
module vxbar_resolve #(
    parameter int NUM_IN  = 2,
    parameter int NUM_OUT = 2,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_OUT*SEL_W-1:0] staged,
    output logic [NUM_OUT*SEL_W-1:0] legal
);

    // Priority resolution: the lowest output claiming an input keeps it.
    always_comb begin
        legal = '0;
        for (int o = 0; o < NUM_OUT; o++) begin
            logic [SEL_W-1:0] sel;
            logic             ok;
            sel = staged[o*SEL_W +: SEL_W];
            ok  = (sel != '0) && (int'(sel) <= NUM_IN);
            for (int p = 0; p < o; p++) begin
                if (staged[p*SEL_W +: SEL_W] == sel) ok = 1'b0;
            end
            legal[o*SEL_W +: SEL_W] = ok ? sel : '0;
        end
    end

endmodule

// File: rtl/vxbar_seq.sv
// Module: run/drain/stop sequencer. Holds the working routing, tracks which
// inputs have closed a packet during a drain, and gates the flow per input.
// Assumes the legal routing input is already one-to-one.
module vxbar_seq
    import vxbar_pkg::*;
#(
    parameter int NUM_IN  = 2,
    parameter int NUM_OUT = 2,
    parameter int SEL_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     switch_req,
    input  logic [NUM_OUT*SEL_W-1:0] legal,
    input  logic [NUM_IN-1:0]        in_valid,
    input  logic [NUM_IN-1:0]        in_ready,
    input  logic [NUM_IN-1:0]        in_eop,
    output logic [NUM_OUT*SEL_W-1:0] act_map,
    output logic [NUM_IN-1:0]        pass_en,
    output logic                     busy,
    output logic                     seq_done,
    output xbar_state_e              state
);

    logic [NUM_IN-1:0] routed;
    logic [NUM_IN-1:0] closed_q;
    logic              all_closed;
    logic              leave_run;

    // Which inputs the working routing connects.
    always_comb begin
        routed = '0;
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int i = 0; i < NUM_IN; i++) begin
                if (int'(act_map[o*SEL_W +: SEL_W]) == i + 1) routed[i] = 1'b1;
            end
        end
    end

    assign all_closed = &closed_q;
    assign leave_run  = (state == ST_RUN) && (!enable || switch_req);
    assign seq_done   = (state == ST_STOP) && switch_req;
    assign busy       = (state != ST_STOP);

    // State transitions between running, draining and stopped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STOP;
        end else begin
            unique case (state)
                ST_RUN:   if (leave_run) state <= ST_DRAIN;
                ST_DRAIN: if (all_closed) state <= ST_STOP;
                default:  if (enable || switch_req) state <= ST_RUN;
            endcase
        end
    end

    // Per-input packet-closed flags, seeded on drain entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            closed_q <= '0;
        end else if (leave_run) begin
            closed_q <= ~routed;
        end else if (state == ST_DRAIN) begin
            closed_q <= closed_q | (in_valid & in_ready & in_eop);
        end
    end

    // Working routing: refreshed from the legal staged set while stopped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_map <= '0;
        end else if (state == ST_STOP) begin
            act_map <= legal;
        end
    end

    // Flow gate per input.
    always_comb begin
        unique case (state)
            ST_RUN:   pass_en = '1;
            ST_DRAIN: pass_en = ~closed_q;
            default:  pass_en = '0;
        endcase
    end

endmodule

// File: rtl/vxbar_fabric.sv
// Module: combinational switch fabric. Forwards valid, flags and data from
// the selected input to each output and returns ready to that input.
// Assumes act_map is one-to-one; disabled outputs drive all zeros.
module vxbar_fabric #(
    parameter int NUM_IN  = 2,
    parameter int NUM_OUT = 2,
    parameter int DATA_W  = 24,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_OUT*SEL_W-1:0]  act_map,
    input  logic [NUM_IN-1:0]         pass_en,
    input  logic [NUM_IN-1:0]         in_valid,
    input  logic [NUM_IN-1:0]         in_sop,
    input  logic [NUM_IN-1:0]         in_eop,
    input  logic [NUM_IN*DATA_W-1:0]  in_data,
    output logic [NUM_IN-1:0]         in_ready,
    output logic [NUM_OUT-1:0]        out_valid,
    output logic [NUM_OUT-1:0]        out_sop,
    output logic [NUM_OUT-1:0]        out_eop,
    output logic [NUM_OUT*DATA_W-1:0] out_data,
    input  logic [NUM_OUT-1:0]        out_ready
);

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        // Forward path for output o.
        always_comb begin
            logic [SEL_W-1:0] sel;
            sel = act_map[o*SEL_W +: SEL_W];
            out_valid[o]                 = 1'b0;
            out_sop[o]                   = 1'b0;
            out_eop[o]                   = 1'b0;
            out_data[o*DATA_W +: DATA_W] = '0;
            for (int i = 0; i < NUM_IN; i++) begin
                if (int'(sel) == i + 1) begin
                    out_valid[o]                 = in_valid[i] & pass_en[i];
                    out_sop[o]                   = in_sop[i];
                    out_eop[o]                   = in_eop[i];
                    out_data[o*DATA_W +: DATA_W] = in_data[i*DATA_W +: DATA_W];
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        // Back-pressure path for input i.
        always_comb begin
            in_ready[i] = 1'b0;
            for (int o = 0; o < NUM_OUT; o++) begin
                if (int'(act_map[o*SEL_W +: SEL_W]) == i + 1) begin
                    in_ready[i] = out_ready[o] & pass_en[i];
                end
            end
        end
    end

endmodule

// File: rtl/vxbar.sv
// Module: top of the packet-aligned crossbar. Ties the register file, the
// routing resolver, the sequencer and the fabric together. Assumes
// NUM_IN, NUM_OUT in 1..12 and a reset released on a clock edge.
module vxbar
    import vxbar_pkg::*;
#(
    parameter int NUM_IN  = 2,
    parameter int NUM_OUT = 2,
    parameter int DATA_W  = 24,
    parameter int REG_W   = 8,
    parameter int AW      = $clog2(REG_ROUTE0 + NUM_OUT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_wr,
    input  logic [AW-1:0]             ctl_addr,
    input  logic [REG_W-1:0]          ctl_wdata,
    output logic [REG_W-1:0]          ctl_rdata,
    input  logic [NUM_IN-1:0]         in_valid,
    output logic [NUM_IN-1:0]         in_ready,
    input  logic [NUM_IN-1:0]         in_sop,
    input  logic [NUM_IN-1:0]         in_eop,
    input  logic [NUM_IN*DATA_W-1:0]  in_data,
    output logic [NUM_OUT-1:0]        out_valid,
    input  logic [NUM_OUT-1:0]        out_ready,
    output logic [NUM_OUT-1:0]        out_sop,
    output logic [NUM_OUT-1:0]        out_eop,
    output logic [NUM_OUT*DATA_W-1:0] out_data
);

    localparam int SEL_W = $clog2(NUM_IN + 1);

    logic                     enable;
    logic                     switch_q;
    logic                     busy;
    logic                     seq_done;
    logic [NUM_OUT*SEL_W-1:0] staged;
    logic [NUM_OUT*SEL_W-1:0] legal;
    logic [NUM_OUT*SEL_W-1:0] act_map;
    logic [NUM_IN-1:0]        pass_en;
    xbar_state_e              state;

    vxbar_regs #(
        .NUM_OUT (NUM_OUT),
        .SEL_W   (SEL_W),
        .REG_W   (REG_W),
        .AW      (AW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .addr     (ctl_addr),
        .wdata    (ctl_wdata),
        .rdata    (ctl_rdata),
        .busy     (busy),
        .seq_done (seq_done),
        .enable_o (enable),
        .switch_o (switch_q),
        .staged_o (staged)
    );

    vxbar_resolve #(
        .NUM_IN  (NUM_IN),
        .NUM_OUT (NUM_OUT),
        .SEL_W   (SEL_W)
    ) u_resolve (
        .staged (staged),
        .legal  (legal)
    );

    vxbar_seq #(
        .NUM_IN  (NUM_IN),
        .NUM_OUT (NUM_OUT),
        .SEL_W   (SEL_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .switch_req (switch_q),
        .legal      (legal),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_eop     (in_eop),
        .act_map    (act_map),
        .pass_en    (pass_en),
        .busy       (busy),
        .seq_done   (seq_done),
        .state      (state)
    );

    vxbar_fabric #(
        .NUM_IN  (NUM_IN),
        .NUM_OUT (NUM_OUT),
        .DATA_W  (DATA_W),
        .SEL_W   (SEL_W)
    ) u_fabric (
        .act_map   (act_map),
        .pass_en   (pass_en),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

endmodule

// File: rtl/vxbar_chk.sv
// Module: property checker bound into vxbar. Observes ports and the
// sequencer's state; drives nothing.
module vxbar_chk #(
    parameter int NUM_IN  = 2,
    parameter int NUM_OUT = 2,
    parameter int MAP_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IN-1:0]  in_valid,
    input logic [NUM_IN-1:0]  in_ready,
    input logic [NUM_OUT-1:0] out_valid,
    input logic [NUM_OUT-1:0] out_ready,
    input logic               busy,
    input logic               switch_q,
    input logic               is_run,
    input logic [MAP_W-1:0]   act_map
);

    // R3: beats accepted on the input side match beats accepted on the output side.
    assert_beat_balance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_valid & in_ready) == $countones(out_valid & out_ready));

    // R3: no stream is duplicated onto more outputs than there are valid inputs.
    assert_no_fanout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid) <= $countones(in_valid));

    // R5: the working routing never changes while running without a stop.
    assert_route_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_run && $past(is_run)) |-> $stable(act_map));

    // R7: a halted crossbar moves nothing.
    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (in_ready == '0 && out_valid == '0));

    // R8: when the switch request clears, the crossbar is running again.
    assert_switch_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(switch_q) |-> busy);

endmodule

bind vxbar vxbar_chk #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .MAP_W   (NUM_OUT * $clog2(NUM_IN + 1))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .busy      (busy),
    .switch_q  (switch_q),
    .is_run    (state == vxbar_pkg::ST_RUN),
    .act_map   (act_map)
);

// File: tb/vxbar_tb.sv
module vxbar_tb;
    localparam int NI = 2;
    localparam int NO = 2;
    localparam int DW = 24;
    localparam int RW = 8;
    localparam int AW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_wr = 1'b0;
    logic [AW-1:0]     ctl_addr = '0;
    logic [RW-1:0]     ctl_wdata = '0;
    logic [RW-1:0]     ctl_rdata;
    logic [NI-1:0]     in_valid = '0, in_sop = '0, in_eop = '0, in_ready;
    logic [NI*DW-1:0]  in_data = '0;
    logic [NO-1:0]     out_valid, out_sop, out_eop;
    logic [NO-1:0]     out_ready = '0;
    logic [NO*DW-1:0]  out_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int amap [NO];

    always #5 clk = ~clk;

    vxbar #(.NUM_IN(NI), .NUM_OUT(NO), .DATA_W(DW), .REG_W(RW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
        .out_eop(out_eop), .out_data(out_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_addr = AW'(a); ctl_wdata = RW'(d);
        @(negedge clk);
        ctl_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        ctl_addr = AW'(a);
        #1;
        check(req, 64'(ctl_rdata), 64'(exp));
    endtask

    // Expected fabric outputs from the bench's own routing model (running state).
    task automatic check_fab(input string req);
        logic [NO-1:0]    ev, es, ee;
        logic [NO*DW-1:0] ed;
        logic [NI-1:0]    er;
        ev = '0; es = '0; ee = '0; ed = '0; er = '0;
        for (int o = 0; o < NO; o++) begin
            if (amap[o] != 0) begin
                int s;
                s = amap[o] - 1;
                ev[o] = in_valid[s];
                es[o] = in_sop[s];
                ee[o] = in_eop[s];
                ed[o*DW +: DW] = in_data[s*DW +: DW];
                er[s] = out_ready[o];
            end
        end
        check(req, 64'({out_valid, out_sop, out_eop, out_data, in_ready}),
                   64'({ev, es, ee, ed, er}));
    endtask

    task automatic randomize_inputs();
        in_valid  = NI'($urandom());
        in_sop    = NI'($urandom());
        in_eop    = NI'($urandom());
        out_ready = NO'($urandom());
        for (int i = 0; i < NI; i++) in_data[i*DW +: DW] = DW'($urandom());
    endtask

    task automatic random_phase(input string req, input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            randomize_inputs();
            #1;
            check_fab(req);
        end
        @(negedge clk);
        in_valid = '0; in_sop = '0; in_eop = '0; out_ready = '1;
    endtask

    // One end-of-packet beat on the inputs in mask, accepted at the next edge.
    task automatic eop_beat(input logic [NI-1:0] mask);
        @(negedge clk);
        in_valid = mask; in_eop = mask; out_ready = '1;
        @(negedge clk);
        in_valid = '0; in_eop = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        in_valid = '1;
        #1;
        check("R1 reset held", 64'({out_valid, in_ready}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 64'({out_valid, in_ready}), 64'(0));
        in_valid = '0;
        rd_chk("R1 enable", 0, 0);
        rd_chk("R1 status", 1, 0);
        rd_chk("R1 route0", 3, 0);
        rd_chk("R9 unmapped", 7, 0);

        // Cross routing: out0 <- in1, out1 <- in0.
        wr(3, 2); wr(4, 1);
        rd_chk("R9 route0 readback", 3, 2);
        rd_chk("R9 route1 readback", 4, 1);
        wr(0, 1);
        amap[0] = 2; amap[1] = 1;
        rd_chk("R7 status running", 1, 1);
        random_phase("R2 cross routing", 300);

        // Software halt: each input stalls after its own end-of-packet.
        wr(0, 0);
        rd_chk("R6 draining status", 1, 1);
        eop_beat(2'b01);
        #1;
        check("R6 in0 stalled in1 flowing", 64'(in_ready), 64'(2'b10));
        rd_chk("R6 still busy", 1, 1);
        eop_beat(2'b10);
        @(negedge clk);
        rd_chk("R7 halted status", 1, 0);
        in_valid = '1;
        #1;
        check("R7 halted quiet", 64'({out_valid, in_ready}), 64'(0));
        in_valid = '0;

        // Duplicate selection: lower output wins.
        wr(3, 1); wr(4, 1);
        rd_chk("R7 still halted", 1, 0);
        wr(0, 1);
        amap[0] = 1; amap[1] = 0;
        @(negedge clk);
        in_valid = '1; in_sop = '1; in_eop = '1; out_ready = '1;
        in_data = '1;
        #1;
        check("R4 disabled output zero", 64'({out_valid[1], out_sop[1], out_eop[1], out_data[DW +: DW]}), 64'(0));
        check("R4 unrouted input stalled", 64'(in_ready[1]), 64'(0));
        random_phase("R3 duplicate priority", 100);

        // Write while running: readable, no routing change.
        wr(4, 2);
        rd_chk("R5 readback", 4, 2);
        random_phase("R5 routing unchanged", 60);

        // Self-sequencing switch.
        wr(2, 1);
        rd_chk("R8 switch pending", 2, 1);
        rd_chk("R8 busy during drain", 1, 1);
        eop_beat(2'b01);
        @(negedge clk);
        @(negedge clk);
        rd_chk("R8 switch cleared", 2, 0);
        rd_chk("R8 enable set", 0, 1);
        amap[0] = 1; amap[1] = 2;
        random_phase("R8 new routing", 100);

        // Out-of-range selection disables the output.
        wr(3, 3);
        wr(2, 1);
        eop_beat(2'b11);
        @(negedge clk);
        @(negedge clk);
        rd_chk("R2 switch done", 2, 0);
        amap[0] = 0; amap[1] = 2;
        random_phase("R2 out of range", 100);

        // Asynchronous reset mid-cycle.
        @(negedge clk);
        in_valid = '1; out_ready = '1;
        #2;
        rst_n = 1'b0;
        #1;
        check("R10 async reset", 64'({out_valid, in_ready}), 64'(0));
        rd_chk("R10 status cleared", 1, 0);
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule